// File: doc/BRIEF.md
# Vector Compare Flag Register Transfer

This block holds the three flag registers of a vector unit and moves them to and from 16-bit scalar values. Two of the registers have two halves: a carry / not-equal register and a compare register. Each half has eight lanes. The third register is a compare-extension register with eight lanes. Every lane flag is stored as a full lane-wide mask, either all ones or all zeros.

A scalar move-to writes one register from a 16-bit value and expands each bit into a lane mask. A scalar move-from packs a register back into bits and returns a 32-bit sign-extended result. Both operations pick the register with a small index, and only the two low bits of that index are decoded.

A single-lane write port lets a test environment place an arbitrary mask into one lane. This stands in for the vector arithmetic that would normally set the flags.

Top module: `vcf_regfile`

## Requirements
- R1: After reset every lane of all three registers is zero, a move-from of any index returns 0, and `mf_valid` is 0.
- R2: Only `mt_idx[1:0]` and `mf_idx[1:0]` select a register. Higher index bits have no effect on which register is written or read.
- R3: Index 0 selects the carry / not-equal register and index 1 selects the compare register. For both, scalar bits 7:0 map to the low-half lanes and bits 15:8 map to the high-half lanes. The two registers are independent.
- R4: Within a half, scalar bit i (bit 8+i for the high half) corresponds to lane 7-i. Lane 0 of the low half appears on bit 7, and lane 7 of the high half appears on bit 8.
- R5: A move-to writes each lane as 0xFFFF when its bit is 1 and as 0x0000 when it is 0. A move-to followed by a move-from of the same dual-half register returns the written 16-bit value, sign-extended.
- R6: Indexes 2 and 3 both select the extension register. A move-to stores only `mt_data[7:0]` there, and a move-from of index 2 or 3 returns the eight flags in bits 7:0 with bits 31:8 zero.
- R7: The 16-bit move-from result is sign-extended from bit 15 into bits 31:16 of `mf_data`.
- R8: A move-to updates the register on the clock edge where `mt_en` is sampled. A move-from sampled on that same edge returns the old contents. A move-from in the following cycle returns the new contents. `mf_data` and `mf_valid` appear one cycle after `mf_en`, and `mf_data` holds its value while `mf_en` is low.
- R9: A lane write (`lw_en`, bank code `lw_bank`: 0 carry low, 1 carry high, 2 compare low, 3 compare high, 4 extension) stores `lw_val` into one lane. Such a lane reads back as 1 when its mask is nonzero and as 0 when it is zero. A move-to to the same register in the same cycle wins, and bank codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mt_en | input | 1 | Move-to request |
| mt_idx | input | IDX_W (5) | Move-to register index; low 2 bits decoded |
| mt_data | input | 2*LANES (16) | Move-to scalar value |
| mf_en | input | 1 | Move-from request |
| mf_idx | input | IDX_W (5) | Move-from register index; low 2 bits decoded |
| mf_data | output | OUT_W (32) | Registered, sign-extended move-from result |
| mf_valid | output | 1 | High one cycle after a move-from request |
| lw_en | input | 1 | Single-lane write enable |
| lw_bank | input | 3 | Target half/register code for the lane write |
| lw_lane | input | $clog2(LANES) (3) | Lane number for the lane write |
| lw_val | input | LANE_W (16) | Mask value written into the lane |

## Verification
The bench builds the block with its default parameters: eight lanes of 16 bits and a 5-bit index. With these values both halves of the dual registers and the bit-to-lane reversal can be observed across a full byte. The upper index bits also exist, so the bench can drive them and show they are ignored. Because the lane port takes a 16-bit value, the bench can store masks that are neither all ones nor zero and confirm that any nonzero mask reads as a set flag.

// File: rtl/vcf_pkg.sv
`timescale 1ns/1ps
package vcf_pkg;

  localparam int NUM_BANKS = 5;

  // Bank codes used by the single-lane write port.
  typedef enum logic [2:0] {
    BANK_CO_LO = 3'd0,
    BANK_CO_HI = 3'd1,
    BANK_CC_LO = 3'd2,
    BANK_CC_HI = 3'd3,
    BANK_EXT   = 3'd4
  } bank_e;

  // Register selector after decoding the low index bits.
  typedef enum logic [1:0] {
    SEL_CARRY = 2'd0,
    SEL_CMP   = 2'd1,
    SEL_EXT_A = 2'd2,
    SEL_EXT_B = 2'd3
  } sel_e;

  function automatic sel_e decode_sel(input logic [1:0] low_bits);
    return sel_e'(low_bits);
  endfunction

endpackage

// File: rtl/vcf_flag_bank.sv
`timescale 1ns/1ps
module vcf_flag_bank #(
  parameter int LANES  = 8,
  parameter int LANE_W = 16,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bulk_we,
  input  logic [LANES-1:0]  bulk_bits,
  input  logic              lane_we,
  input  logic [LIDX_W-1:0] lane_idx,
  input  logic [LANE_W-1:0] lane_val,
  output logic [LANES-1:0]  flags
);

  logic [LANE_W-1:0] mask_q [LANES];

  // Bulk write expands bit (LANES-1-j) into lane j; it has priority over the lane port.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < LANES; j++) mask_q[j] <= '0;
    end else if (bulk_we) begin
      for (int j = 0; j < LANES; j++)
        mask_q[j] <= {LANE_W{bulk_bits[LANES-1-j]}};
    end else if (lane_we) begin
      mask_q[lane_idx] <= lane_val;
    end
  end

  // Packed view: bit i reports lane LANES-1-i as set when its mask is nonzero.
  always_comb begin
    for (int i = 0; i < LANES; i++) flags[i] = |mask_q[LANES-1-i];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (flags == '0)); // R1

  AST_BULK_ROUNDTRIP: assert property (@(posedge clk) disable iff (rst)
    bulk_we |=> (flags == $past(bulk_bits))); // R4

  for (genvar g = 0; g < LANES; g++) begin : g_mask_chk
    AST_BULK_FULL_MASK: assert property (@(posedge clk) disable iff (rst)
      bulk_we |=> ((mask_q[g] == '0) || (mask_q[g] == '1))); // R5
  end

  AST_LANE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (lane_we && !bulk_we) |=>
      (flags[LANES-1-int'($past(lane_idx))] == (|$past(lane_val)))); // R9

endmodule

// File: rtl/vcf_read_port.sv
`timescale 1ns/1ps
module vcf_read_port
  import vcf_pkg::*;
#(
  parameter int LANES = 8,
  parameter int IDX_W = 5,
  parameter int OUT_W = 32,
  localparam int SCALAR_W = 2 * LANES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic [NUM_BANKS*LANES-1:0] bank_flags,
  output logic [OUT_W-1:0]           rd_data,
  output logic                       rd_valid
);

  logic [SCALAR_W-1:0] packed_val;
  logic [OUT_W-1:0]    wide_val;
  sel_e                sel;

  always_comb begin
    sel = decode_sel(rd_idx[1:0]);
    unique case (sel)
      SEL_CARRY: packed_val = {bank_flags[BANK_CO_HI*LANES +: LANES],
                               bank_flags[BANK_CO_LO*LANES +: LANES]};
      SEL_CMP:   packed_val = {bank_flags[BANK_CC_HI*LANES +: LANES],
                               bank_flags[BANK_CC_LO*LANES +: LANES]};
      default:   packed_val = {{LANES{1'b0}},
                               bank_flags[BANK_EXT*LANES +: LANES]};
    endcase
    wide_val = {{(OUT_W-SCALAR_W){packed_val[SCALAR_W-1]}}, packed_val};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= wide_val;
    end
  end

  AST_EXT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_idx[1]) |=> (rd_data[OUT_W-1:LANES] == '0)); // R6

  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (($countones(rd_data[OUT_W-1:SCALAR_W-1]) == 0) ||
                  ($countones(rd_data[OUT_W-1:SCALAR_W-1]) == OUT_W-SCALAR_W+1))); // R7

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R8

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && $stable(rd_data))); // R8

endmodule

// File: rtl/vcf_regfile.sv
`timescale 1ns/1ps
module vcf_regfile
  import vcf_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 16,
  parameter int IDX_W  = 5,
  parameter int OUT_W  = 32,
  localparam int SCALAR_W = 2 * LANES,
  localparam int LIDX_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mt_en,
  input  logic [IDX_W-1:0]    mt_idx,
  input  logic [SCALAR_W-1:0] mt_data,
  input  logic                mf_en,
  input  logic [IDX_W-1:0]    mf_idx,
  output logic [OUT_W-1:0]    mf_data,
  output logic                mf_valid,
  input  logic                lw_en,
  input  logic [2:0]          lw_bank,
  input  logic [LIDX_W-1:0]   lw_lane,
  input  logic [LANE_W-1:0]   lw_val
);

  logic [NUM_BANKS-1:0]       bulk_we;
  logic [NUM_BANKS-1:0]       lane_we;
  logic [LANES-1:0]           bulk_bits [NUM_BANKS];
  logic [NUM_BANKS*LANES-1:0] all_flags;
  sel_e                       wr_sel;

  assign wr_sel = decode_sel(mt_idx[1:0]);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    if (k == int'(BANK_EXT)) begin : g_ext
      assign bulk_we[k]   = mt_en && ((wr_sel == SEL_EXT_A) || (wr_sel == SEL_EXT_B));
      assign bulk_bits[k] = mt_data[LANES-1:0];
    end else begin : g_dual
      localparam sel_e OWNER = sel_e'(k / 2);
      assign bulk_we[k] = mt_en && (wr_sel == OWNER);
      if (k % 2 == 1) begin : g_hi
        assign bulk_bits[k] = mt_data[SCALAR_W-1:LANES];
      end else begin : g_lo
        assign bulk_bits[k] = mt_data[LANES-1:0];
      end
    end

    assign lane_we[k] = lw_en && (lw_bank == 3'(k));

    vcf_flag_bank #(.LANES(LANES), .LANE_W(LANE_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .bulk_we   (bulk_we[k]),
      .bulk_bits (bulk_bits[k]),
      .lane_we   (lane_we[k]),
      .lane_idx  (lw_lane),
      .lane_val  (lw_val),
      .flags     (all_flags[k*LANES +: LANES])
    );
  end

  vcf_read_port #(.LANES(LANES), .IDX_W(IDX_W), .OUT_W(OUT_W)) u_read (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (mf_en),
    .rd_idx     (mf_idx),
    .bank_flags (all_flags),
    .rd_data    (mf_data),
    .rd_valid   (mf_valid)
  );

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
    mt_en |-> ($countones(bulk_we) inside {1, 2})); // R2

  AST_EXT_ALIAS: assert property (@(posedge clk) disable iff (rst)
    (mt_en && mt_idx[1]) |=> (all_flags[BANK_EXT*LANES +: LANES] == $past(mt_data[LANES-1:0]))); // R6

endmodule

// File: tb/vcf_regfile_test.sv
`timescale 1ns/1ps
module vcf_regfile_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        mt_en, mf_en, lw_en;
  logic [4:0]  mt_idx, mf_idx;
  logic [15:0] mt_data, lw_val;
  logic [2:0]  lw_bank, lw_lane;
  logic [31:0] mf_data;
  logic        mf_valid;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vcf_regfile uut (
    .clk(clk), .rst(rst),
    .mt_en(mt_en), .mt_idx(mt_idx), .mt_data(mt_data),
    .mf_en(mf_en), .mf_idx(mf_idx), .mf_data(mf_data), .mf_valid(mf_valid),
    .lw_en(lw_en), .lw_bank(lw_bank), .lw_lane(lw_lane), .lw_val(lw_val)
  );

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_mt(input logic [4:0] idx, input logic [15:0] d);
    @(negedge clk); mt_en = 1; mt_idx = idx; mt_data = d;
    @(negedge clk); mt_en = 0;
  endtask

  task automatic do_lw(input logic [2:0] b, input logic [2:0] ln, input logic [15:0] v);
    @(negedge clk); lw_en = 1; lw_bank = b; lw_lane = ln; lw_val = v;
    @(negedge clk); lw_en = 0;
  endtask

  task automatic do_mf(input logic [4:0] idx, output logic [31:0] d);
    @(negedge clk); mf_en = 1; mf_idx = idx;
    @(negedge clk); mf_en = 0;
    chk("R8 valid", {31'b0, mf_valid}, 32'd1);
    d = mf_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 valid", {31'b0, mf_valid}, 32'd0);
    chk("R1 data", mf_data, 32'd0);
    for (int i = 0; i < 4; i++) begin
      do_mf(5'(i), d); chk("R1 read", d, 32'd0);
    end
  endtask

  task automatic t_carry_cmp();
    logic [31:0] d;
    do_mt(5'd0, 16'hA5C3);
    do_mf(5'd0, d); chk("R3 carry", d, sx(16'hA5C3));
    do_mf(5'd1, d); chk("R3 cmp untouched", d, 32'd0);
    do_mt(5'd1, 16'h1234);
    do_mf(5'd1, d); chk("R7 positive", d, 32'h0000_1234);
    do_mf(5'd0, d); chk("R3 carry kept", d, 32'hFFFF_A5C3);
  endtask

  task automatic t_roundtrip();
    logic [31:0] d;
    logic [15:0] pats [4] = '{16'hFFFF, 16'h8001, 16'h7FFE, 16'h00FF};
    foreach (pats[p]) begin
      do_mt(5'd1, pats[p]);
      do_mf(5'd1, d); chk("R5 roundtrip", d, sx(pats[p]));
    end
  endtask

  task automatic t_ext();
    logic [31:0] d;
    do_mt(5'd2, 16'hFF5A);
    do_mf(5'd2, d); chk("R6 ext idx2", d, 32'h5A);
    do_mf(5'd3, d); chk("R6 ext idx3 alias", d, 32'h5A);
    do_mt(5'd3, 16'h0081);
    do_mf(5'd2, d); chk("R6 ext bit7 no sign", d, 32'h81);
  endtask

  task automatic t_index_upper();
    logic [31:0] d;
    do_mt(5'd0, 16'hA5C3);
    do_mt(5'b10101, 16'h00F0);
    do_mf(5'd1, d); chk("R2 upper ignored write", d, 32'hF0);
    do_mf(5'b11100, d); chk("R2 upper ignored read", d, 32'hFFFF_A5C3);
  endtask

  task automatic t_lane_order();
    logic [31:0] d;
    do_mt(5'd0, 16'h0000);
    do_lw(3'd0, 3'd0, 16'h0001);
    do_mf(5'd0, d); chk("R4 lane0 low -> bit7", d, 32'h80);
    do_mt(5'd1, 16'h0000);
    do_lw(3'd3, 3'd7, 16'h8000);
    do_mf(5'd1, d); chk("R4 lane7 high -> bit8", d, 32'h100);
    do_lw(3'd4, 3'd0, 16'h0300);
    do_mf(5'd2, d); chk("R9 ext partial mask", d, 32'h81);
  endtask

  task automatic t_lane_priority();
    logic [31:0] d;
    do_lw(3'd0, 3'd0, 16'h0000);
    do_mf(5'd0, d); chk("R9 zero mask", d, 32'h0);
    @(negedge clk);
    mt_en = 1; mt_idx = 5'd0; mt_data = 16'h0000;
    lw_en = 1; lw_bank = 3'd0; lw_lane = 3'd3; lw_val = 16'hFFFF;
    @(negedge clk); mt_en = 0; lw_en = 0;
    do_mf(5'd0, d); chk("R9 move-to wins", d, 32'h0);
    do_lw(3'd6, 3'd1, 16'hFFFF);
    do_mf(5'd0, d); chk("R9 bad bank carry", d, 32'h0);
    do_mf(5'd1, d); chk("R9 bad bank cmp", d, 32'h100);
    do_mf(5'd2, d); chk("R9 bad bank ext", d, 32'h81);
  endtask

  task automatic t_timing();
    logic [31:0] held;
    @(negedge clk);
    mt_en = 1; mt_idx = 5'd1; mt_data = 16'h00FF;
    mf_en = 1; mf_idx = 5'd1;
    @(negedge clk);
    mt_en = 0;
    chk("R8 same-cycle old", mf_data, 32'h100);
    @(negedge clk);
    mf_en = 0;
    chk("R8 next-cycle new", mf_data, 32'hFF);
    held = mf_data;
    do_mt(5'd1, 16'hFFFF);
    chk("R8 idle valid low", {31'b0, mf_valid}, 32'd0);
    chk("R8 idle hold", mf_data, held);
  endtask

  initial begin
    rst = 1; mt_en = 0; mf_en = 0; lw_en = 0;
    mt_idx = 0; mf_idx = 0; mt_data = 0; lw_bank = 0; lw_lane = 0; lw_val = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_carry_cmp();
    t_roundtrip();
    t_ext();
    t_index_upper();
    t_lane_order();
    t_lane_priority();
    t_timing();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule